// File: doc/BRIEF.md
# Serial Channel Host Register Bank

This block is the processor-facing register file of one asynchronous serial channel of the 16550 family. A host issues single-cycle read or write accesses through a 3-bit address. The block decodes each access and stores the configuration registers: interrupt enable, line control, modem control, scratch and the 16-bit baud divisor. Accesses to the transmit holding register and the FIFO control register become one-cycle strobes. Read data for the receive buffer, interrupt identification, line status and modem status is assembled from status inputs. The shifters, FIFOs, baud generator and interrupt prioritiser sit outside and connect through these strobes and status pins.

Bit 7 of the line control register switches addresses 0 and 1 from the data/enable registers to the divisor bytes. Address 2 means one register on a read and another on a write. Once the FIFOs are on, the line status byte reports on the whole receive FIFO rather than on a single holding register. The block also flags whether each direction is running in polled mode.

Read data is registered. `rdData` takes its new value at the clock edge that samples `rdEn` and keeps it until the next read. Strobes are combinational and last for the cycle in which the access is presented.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the enable, line control, modem control, scratch and divisor registers, `fifoEn` and `rdData` are all zero.
- R2: When line-control bit 7 (the divisor-access bit) is 0, a write to address 0 raises `thrWrStb` in that cycle and changes no stored register. A read of address 0 raises `rbrRdStb` in that cycle and returns `rxData`.
- R3: When the divisor-access bit is 0, address 1 is the interrupt enable register. Only write-data bits 3:0 are stored. It reads back with bits 7:4 zero. Bit 0 enables the receive interrupt and bit 1 enables the transmit-empty interrupt.
- R4: When the divisor-access bit is 1, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. Neither `thrWrStb` nor `rbrRdStb` is raised, and the enable register is unchanged.
- R5: A write to address 2 raises `fcrWrStb`, loads `fifoEn` from write-data bit 0, and raises `rxFifoRstStb` in the same cycle when write-data bit 1 is 1.
- R6: A read of address 2 returns {fifoEn, fifoEn, 2'b00, intCode, ~intPending}, raises `iirRdStb`, and leaves `fifoEn` unchanged.
- R7: Address 3 stores and returns all 8 bits of line control. Address 7 stores and returns all 8 bits of scratch.
- R8: Address 4 stores modem-control bits 4:0 (bit 0 drives DTR and bit 1 drives RTS). It reads back with bits 7:5 zero.
- R9: A read of address 5 returns line status. The bits are: bit 0 = `rxAvail`; bits 4:1 = `rxErr`; bit 5 = `txFifoEmpty`; bit 6 = `txFifoEmpty` AND `txShiftEmpty`; bit 7 = `rxFifoAnyErr` when `fifoEn` is 1, otherwise 0.
- R10: A read of address 6 returns `msrIn`. Writes to addresses 5 and 6 change no register and raise no strobe.
- R11: `rxPolled` equals `fifoEn` AND NOT enable bit 0. `txPolled` equals `fifoEn` AND NOT enable bit 1.
- R12: `rdData` changes only at an edge that samples `rdEn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write access this cycle |
| rdEn | input | 1 | Read access this cycle |
| wrData | input | 8 | Write data; also the byte taken by the transmitter on `thrWrStb` |
| rdData | output | 8 | Registered read data |
| rxData | input | 8 | Byte at the head of the receive path |
| rxAvail | input | 1 | Receive path holds at least one byte |
| rxErr | input | 4 | Error flags of the head byte (overrun, parity, framing, break) |
| rxFifoAnyErr | input | 1 | Some byte in the receive FIFO carries an error |
| txFifoEmpty | input | 1 | Transmit FIFO or holding register empty |
| txShiftEmpty | input | 1 | Transmit shift register empty |
| intPending | input | 1 | Interrupt prioritiser has a pending source |
| intCode | input | 3 | Identity of the highest pending source |
| msrIn | input | 8 | Modem status byte |
| thrWrStb | output | 1 | Transmit holding register write |
| rbrRdStb | output | 1 | Receive buffer read (pop) |
| iirRdStb | output | 1 | Interrupt identification read |
| fcrWrStb | output | 1 | FIFO control write |
| rxFifoRstStb | output | 1 | Receive FIFO clear request |
| fifoEn | output | 1 | FIFOs enabled |
| ierOut | output | 4 | Interrupt enable bits |
| lcrOut | output | 8 | Line control register |
| mcrOut | output | 5 | Modem control bits |
| divisor | output | 16 | Baud divisor |
| rxPolled | output | 1 | Receive direction in FIFO polled mode |
| txPolled | output | 1 | Transmit direction in FIFO polled mode |

## Verification
A wrong decode shows up in one of two ways. It raises a strobe in the same cycle as the access, where it should stay low. Or it puts a stored byte on `rdData` one edge after the read, instead of status or divisor data. Corruption of a stored register shows on its dedicated output immediately after the edge. A lost divisor-access bit becomes visible at the next address 0 or 1 access. A wrong `fifoEn` shows at the next line status or identification read, and continuously on the polled-mode flags.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [3:0] {
    SEL_RBR, SEL_IER, SEL_IIR, SEL_LCR, SEL_MCR,
    SEL_LSR, SEL_MSR, SEL_SCR, SEL_DLL, SEL_DLM
  } rdSel_e;

  typedef struct packed {
    logic   wrThr;
    logic   wrIer;
    logic   wrFcr;
    logic   wrLcr;
    logic   wrMcr;
    logic   wrScr;
    logic   wrDll;
    logic   wrDlm;
    logic   rdAny;
    logic   rdRbr;
    logic   rdIir;
    rdSel_e rdSel;
  } regStb_t;

endpackage

// File: rtl/uart_regbank_ctrl.sv
module uart_regbank_ctrl
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dlab,
  output regStb_t           stb
);

  always_comb begin
    stb = '0;
    stb.rdAny = rdEn;
    case (addr)
      3'd0: begin
        stb.rdSel = dlab ? SEL_DLL : SEL_RBR;
        stb.wrDll = wrEn & dlab;
        stb.wrThr = wrEn & ~dlab;
        stb.rdRbr = rdEn & ~dlab;
      end
      3'd1: begin
        stb.rdSel = dlab ? SEL_DLM : SEL_IER;
        stb.wrDlm = wrEn & dlab;
        stb.wrIer = wrEn & ~dlab;
      end
      3'd2: begin
        stb.rdSel = SEL_IIR;
        stb.wrFcr = wrEn;
        stb.rdIir = rdEn;
      end
      3'd3: begin
        stb.rdSel = SEL_LCR;
        stb.wrLcr = wrEn;
      end
      3'd4: begin
        stb.rdSel = SEL_MCR;
        stb.wrMcr = wrEn;
      end
      3'd5: stb.rdSel = SEL_LSR;
      3'd6: stb.rdSel = SEL_MSR;
      default: begin
        stb.rdSel = SEL_SCR;
        stb.wrScr = wrEn;
      end
    endcase
  end

  // R2/R4: the holding-register and divisor-low writes can never coincide
  always_comb begin
    a_r4_dl_thr_excl: assert (!(stb.wrThr && stb.wrDll));
  end

endmodule

// File: rtl/uart_regbank_dp.sv
module uart_regbank_dp
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IER_W  = 4,
  parameter int MCR_W  = 5,
  parameter int ERR_W  = 4,
  parameter int ID_W   = 3,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxAvail,
  input  logic [ERR_W-1:0]  rxErr,
  input  logic              rxFifoAnyErr,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  input  logic              intPending,
  input  logic [ID_W-1:0]   intCode,
  input  logic [DATA_W-1:0] msrIn,
  output logic [DATA_W-1:0] rdData,
  output logic              fifoEn,
  output logic [IER_W-1:0]  ierQ,
  output logic [DATA_W-1:0] lcrQ,
  output logic [MCR_W-1:0]  mcrQ,
  output logic [DIV_W-1:0]  divQ
);

  logic [DATA_W-1:0] scrQ;
  logic [DATA_W-1:0] lsrVal;
  logic [DATA_W-1:0] iirVal;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ   <= '0;
      lcrQ   <= '0;
      mcrQ   <= '0;
      scrQ   <= '0;
      divQ   <= '0;
      fifoEn <= 1'b0;
    end else begin
      if (stb.wrIer) ierQ <= wrData[IER_W-1:0];
      if (stb.wrLcr) lcrQ <= wrData;
      if (stb.wrMcr) mcrQ <= wrData[MCR_W-1:0];
      if (stb.wrScr) scrQ <= wrData;
      if (stb.wrDll) divQ[DATA_W-1:0] <= wrData;
      if (stb.wrDlm) divQ[DIV_W-1:DATA_W] <= wrData;
      if (stb.wrFcr) fifoEn <= wrData[0];
    end
  end

  always_comb begin
    lsrVal = '0;
    lsrVal[0] = rxAvail;
    lsrVal[ERR_W:1] = rxErr;
    lsrVal[5] = txFifoEmpty;
    lsrVal[6] = txFifoEmpty & txShiftEmpty;
    lsrVal[7] = fifoEn & rxFifoAnyErr;
  end

  always_comb begin
    iirVal = '0;
    iirVal[0] = ~intPending;
    iirVal[ID_W:1] = intCode;
    iirVal[7] = fifoEn;
    iirVal[6] = fifoEn;
  end

  always_comb begin
    case (stb.rdSel)
      SEL_RBR: rdNext = rxData;
      SEL_IER: rdNext = {{(DATA_W-IER_W){1'b0}}, ierQ};
      SEL_IIR: rdNext = iirVal;
      SEL_LCR: rdNext = lcrQ;
      SEL_MCR: rdNext = {{(DATA_W-MCR_W){1'b0}}, mcrQ};
      SEL_LSR: rdNext = lsrVal;
      SEL_MSR: rdNext = msrIn;
      SEL_SCR: rdNext = scrQ;
      SEL_DLL: rdNext = divQ[DATA_W-1:0];
      default: rdNext = divQ[DIV_W-1:DATA_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdAny) rdData <= rdNext;
  end

  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdAny |=> $stable(rdData));
  a_r5_fifo_en_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrFcr |=> fifoEn == $past(wrData[0]));
  a_r6_iir_read_keeps_fifo: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdIir && !stb.wrFcr) |=> $stable(fifoEn));
  a_r2_thr_keeps_div: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrThr |=> ($stable(divQ) && $stable(scrQ)));
  a_r4_dlm_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDlm |=> divQ[DIV_W-1:DATA_W] == $past(wrData));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int IER_W  = 4,
  parameter int MCR_W  = 5,
  parameter int ERR_W  = 4,
  parameter int ID_W   = 3,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxAvail,
  input  logic [ERR_W-1:0]  rxErr,
  input  logic              rxFifoAnyErr,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  input  logic              intPending,
  input  logic [ID_W-1:0]   intCode,
  input  logic [DATA_W-1:0] msrIn,
  output logic              thrWrStb,
  output logic              rbrRdStb,
  output logic              iirRdStb,
  output logic              fcrWrStb,
  output logic              rxFifoRstStb,
  output logic              fifoEn,
  output logic [IER_W-1:0]  ierOut,
  output logic [DATA_W-1:0] lcrOut,
  output logic [MCR_W-1:0]  mcrOut,
  output logic [DIV_W-1:0]  divisor,
  output logic              rxPolled,
  output logic              txPolled
);

  regStb_t stb;

  uart_regbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .dlab (lcrOut[DATA_W-1]),
    .stb  (stb)
  );

  uart_regbank_dp #(
    .DATA_W(DATA_W), .IER_W(IER_W), .MCR_W(MCR_W), .ERR_W(ERR_W), .ID_W(ID_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .rxData       (rxData),
    .rxAvail      (rxAvail),
    .rxErr        (rxErr),
    .rxFifoAnyErr (rxFifoAnyErr),
    .txFifoEmpty  (txFifoEmpty),
    .txShiftEmpty (txShiftEmpty),
    .intPending   (intPending),
    .intCode      (intCode),
    .msrIn        (msrIn),
    .rdData       (rdData),
    .fifoEn       (fifoEn),
    .ierQ         (ierOut),
    .lcrQ         (lcrOut),
    .mcrQ         (mcrOut),
    .divQ         (divisor)
  );

  assign thrWrStb     = stb.wrThr;
  assign rbrRdStb     = stb.rdRbr;
  assign iirRdStb     = stb.rdIir;
  assign fcrWrStb     = stb.wrFcr;
  assign rxFifoRstStb = stb.wrFcr & wrData[1];
  assign rxPolled     = fifoEn & ~ierOut[0];
  assign txPolled     = fifoEn & ~ierOut[1];

  a_r10_status_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == 3'd5 || addr == 3'd6)) |=>
      ($stable(lcrOut) && $stable(ierOut) && $stable(mcrOut) && $stable(divisor)));
  a_r11_rx_polled: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && !ierOut[0]) |-> rxPolled);

endmodule

// File: tb/uart_regbank_tb.sv
`timescale 1ns/1ps
module uart_regbank_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  addr;
  logic        wrEn, rdEn;
  logic [7:0]  wrData, rdData, rxData, msrIn, lcrOut;
  logic        rxAvail, rxFifoAnyErr, txFifoEmpty, txShiftEmpty, intPending;
  logic [3:0]  rxErr, ierOut;
  logic [2:0]  intCode;
  logic        thrWrStb, rbrRdStb, iirRdStb, fcrWrStb, rxFifoRstStb, fifoEn;
  logic [4:0]  mcrOut;
  logic [15:0] divisor;
  logic        rxPolled, txPolled;

  int total = 0;
  int bad   = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  uart_regbank u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxData(rxData), .rxAvail(rxAvail),
    .rxErr(rxErr), .rxFifoAnyErr(rxFifoAnyErr), .txFifoEmpty(txFifoEmpty),
    .txShiftEmpty(txShiftEmpty), .intPending(intPending), .intCode(intCode),
    .msrIn(msrIn), .thrWrStb(thrWrStb), .rbrRdStb(rbrRdStb),
    .iirRdStb(iirRdStb), .fcrWrStb(fcrWrStb), .rxFifoRstStb(rxFifoRstStb),
    .fifoEn(fifoEn), .ierOut(ierOut), .lcrOut(lcrOut), .mcrOut(mcrOut),
    .divisor(divisor), .rxPolled(rxPolled), .txPolled(txPolled)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write cycle; returns the strobes seen during it as {thr,fcr,rxrst}
  task automatic wr(input logic [2:0] a, input logic [7:0] d, output logic [2:0] s);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    #1 s = {thrWrStb, fcrWrStb, rxFifoRstStb};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // one read cycle; returns data and strobes {rbr,iir}
  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [1:0] s);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 s = {rbrRdStb, iirRdStb};
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic t_reset();
    chk("R1 ier", {12'h0, ierOut}, 16'h0);
    chk("R1 lcr", {8'h0, lcrOut}, 16'h0);
    chk("R1 mcr", {11'h0, mcrOut}, 16'h0);
    chk("R1 div", divisor, 16'h0);
    chk("R1 fifoEn", {15'h0, fifoEn}, 16'h0);
    chk("R1 rdData", {8'h0, rdData}, 16'h0);
  endtask

  task automatic t_scr_lcr();
    logic [2:0] s; logic [1:0] r;
    wr(3'd7, 8'hA5, s); rd(3'd7, rv, r);
    chk("R7 scratch", {8'h0, rv}, 16'h00A5);
    wr(3'd3, 8'h1B, s); rd(3'd3, rv, r);
    chk("R7 lcr", {8'h0, rv}, 16'h001B);
    chk("R7 lcrOut", {8'h0, lcrOut}, 16'h001B);
  endtask

  task automatic t_thr_rbr();
    logic [2:0] s; logic [1:0] r;
    wr(3'd0, 8'h3C, s);
    chk("R2 thr strobe", {13'h0, s}, 16'b100);
    chk("R2 div untouched", divisor, 16'h0);
    rxData = 8'hE7;
    rd(3'd0, rv, r);
    chk("R2 rbr data", {8'h0, rv}, 16'h00E7);
    chk("R2 rbr strobe", {14'h0, r}, 16'b10);
  endtask

  task automatic t_ier();
    logic [2:0] s; logic [1:0] r;
    wr(3'd1, 8'hFA, s); rd(3'd1, rv, r);
    chk("R3 ier readback", {8'h0, rv}, 16'h000A);
    chk("R3 ierOut", {12'h0, ierOut}, 16'h000A);
  endtask

  task automatic t_divisor();
    logic [2:0] s; logic [1:0] r;
    wr(3'd3, 8'h83, s);
    wr(3'd0, 8'h34, s);
    chk("R4 no thr strobe", {13'h0, s}, 16'h0);
    wr(3'd1, 8'h12, s);
    chk("R4 divisor", divisor, 16'h1234);
    chk("R4 ier unchanged", {12'h0, ierOut}, 16'h000A);
    rd(3'd0, rv, r);
    chk("R4 dll read", {8'h0, rv}, 16'h0034);
    chk("R4 no rbr strobe", {14'h0, r}, 16'h0);
    rd(3'd1, rv, r);
    chk("R4 dlm read", {8'h0, rv}, 16'h0012);
    wr(3'd3, 8'h03, s);
    rd(3'd1, rv, r);
    chk("R4 ier back after dlab clear", {8'h0, rv}, 16'h000A);
  endtask

  task automatic t_fcr_iir();
    logic [2:0] s; logic [1:0] r;
    intPending = 1'b1; intCode = 3'b010;
    rd(3'd2, rv, r);
    chk("R6 iir fifo off", {8'h0, rv}, 16'h0004);
    chk("R6 iir strobe", {14'h0, r}, 16'b01);
    wr(3'd2, 8'h03, s);
    chk("R5 fcr strobes", {13'h0, s}, 16'b011);
    chk("R5 fifoEn set", {15'h0, fifoEn}, 16'h1);
    intPending = 1'b0; intCode = 3'b110;
    rd(3'd2, rv, r);
    chk("R6 iir fifo on", {8'h0, rv}, 16'h00CD);
    chk("R6 fifoEn kept", {15'h0, fifoEn}, 16'h1);
  endtask

  task automatic t_lsr();
    logic [1:0] r; logic [2:0] s;
    rxAvail = 1'b1; rxErr = 4'b0101; txFifoEmpty = 1'b1; txShiftEmpty = 1'b0;
    rxFifoAnyErr = 1'b1;
    rd(3'd5, rv, r);
    chk("R9 lsr fifo on", {8'h0, rv}, 16'h00AB);
    txShiftEmpty = 1'b1; rxAvail = 1'b0; rxErr = 4'b0;
    rd(3'd5, rv, r);
    chk("R9 lsr both empty", {8'h0, rv}, 16'h00E0);
    wr(3'd2, 8'h00, s);
    rd(3'd5, rv, r);
    chk("R9 lsr bit7 masked fifo off", {8'h0, rv}, 16'h0060);
  endtask

  task automatic t_msr_inert();
    logic [2:0] s; logic [1:0] r;
    msrIn = 8'h5E;
    rd(3'd6, rv, r);
    chk("R10 msr", {8'h0, rv}, 16'h005E);
    wr(3'd5, 8'hFF, s);
    chk("R10 lsr write no strobe", {13'h0, s}, 16'h0);
    wr(3'd6, 8'hFF, s);
    chk("R10 msr write no strobe", {13'h0, s}, 16'h0);
    chk("R10 regs unchanged", {lcrOut, ierOut, 4'h0}, {8'h03, 4'hA, 4'h0});
    rd(3'd7, rv, r);
    chk("R10 scratch unchanged", {8'h0, rv}, 16'h00A5);
  endtask

  task automatic t_mcr();
    logic [2:0] s; logic [1:0] r;
    wr(3'd4, 8'hFF, s); rd(3'd4, rv, r);
    chk("R8 mcr readback", {8'h0, rv}, 16'h001F);
    wr(3'd4, 8'h02, s);
    chk("R8 rts only", {11'h0, mcrOut}, 16'h0002);
  endtask

  task automatic t_polled();
    logic [2:0] s;
    chk("R11 fifo off", {14'h0, rxPolled, txPolled}, 16'b00);
    wr(3'd2, 8'h01, s);
    chk("R11 ier=A", {14'h0, rxPolled, txPolled}, 16'b10);
    wr(3'd1, 8'h01, s);
    chk("R11 ier=1", {14'h0, rxPolled, txPolled}, 16'b01);
  endtask

  task automatic t_hold();
    logic [1:0] r; logic [2:0] s;
    msrIn = 8'h77;
    rd(3'd6, rv, r);
    msrIn = 8'h11;
    wr(3'd7, 8'h99, s);
    repeat (3) @(negedge clk);
    chk("R12 rdData held", {8'h0, rdData}, 16'h0077);
  endtask

  initial begin
    rstN = 1'b0; addr = '0; wrEn = 0; rdEn = 0; wrData = '0; rxData = '0;
    rxAvail = 0; rxErr = '0; rxFifoAnyErr = 0; txFifoEmpty = 0;
    txShiftEmpty = 0; intPending = 0; intCode = '0; msrIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_scr_lcr();
    t_thr_rbr();
    t_ier();
    t_divisor();
    t_fcr_iir();
    t_lsr();
    t_msr_inert();
    t_mcr();
    t_polled();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule